// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block is the front end of a NAND flash device model. It watches an 8-bit I/O bus together with an active-low chip enable, a command latch strobe, an address latch strobe and a byte-valid qualifier. It sorts each qualified byte into a command or an address byte. It keeps the current command, gathers the multi-byte address with the least significant byte first, and holds the column start offset that the read variants select. When an operation is ready to start, it sends a one-cycle execute pulse with an operation code to the storage datapath behind it.

Two parameters set the geometry. `LARGE_PAGE` chooses 2048-byte pages with the large-page command extensions, or 512-byte pages. `BIG_CAP` chooses a large-page part of 2 Gbit or more. Together they fix how many address bytes a read or a program setup needs before it starts. `BUS16` models a 16-bit data bus, where the column is given in words and is turned into a byte address. Program and erase commits are held back while the write-protect input is asserted.

Top module: `nand_cmd_seq`

## Requirements
- R1: After asynchronous reset, the current command is 0x00, and the address, address-byte count and column offset are all 0. `exec_o` and `err_o` are low.
- R2: A byte is taken only in a cycle with `we_i` high and `ce_ni` low. It is a command when `cle_i` is high. It is an address byte when `ale_i` is high and `cle_i` is low, and it fills byte lane `addr_cnt_o` of `addr_o`, least significant lane first. While `ce_ni` is high, bytes change neither the command nor the address.
- R3: Opcode 0x00 sets the column offset to 0. Opcode 0x01 sets it to 0x100. Opcode 0x50 sets it to the page size (0x800 for large page, 0x200 for small page). All three leave the current command at 0x00.
- R4: With the command at 0x00 or 0x80, a read (op 1) or a program setup (op 4) starts on the address byte that brings the count to 3 for small page, 4 for large page below 2 Gbit, or 5 for large page of 2 Gbit or more. With the command at 0x90, a read-ID (op 2) starts on the first address byte. The count stops at 5, and any further address bytes are dropped.
- R5: Several opcodes start at once, on the command byte itself. Status 0x70 gives op 8. Program confirm 0x10 gives op 5. Erase setup 0x60 gives op 6. Erase confirm 0xD0 gives op 7. Reset 0xFF gives op 9. In large-page mode, 0xE0 and 0x35 give op 3 (random read).
- R6: Every accepted command except 0xE0 clears the address-byte count. 0xE0 keeps it.
- R7: In large-page mode, 0x30 is ignored while the current command is 0x00. In that mode, 0x05 clears the low 16 address bits and the count, and leaves the command unchanged. In small-page mode, both opcodes count as unknown.
- R8: On erase confirm, the address shifts left by 16 bits (large page) or 8 bits (small page), truncated to 40 bits. The shift happens whether or not the part is protected.
- R9: A program confirm or an erase confirm raises `exec_o` only when `wp_ni` is high.
- R10: With `BUS16` set, the whole address shifts left by one bit when the second address byte is stored.
- R11: Opcode 0xFF clears the command to 0x00, and clears the address, the count and the column offset in the same cycle as its op 9 pulse.
- R12: An unknown opcode raises `err_o` for one cycle. It starts nothing and changes neither the command nor the address.
- R13: Each start gives exactly one `exec_o` pulse with its `exec_op_o` code. Both the pulse and `err_o` come in the cycle after the edge that sampled the byte, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Byte valid on the bus this cycle |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch strobe |
| ale_i | input | 1 | Address latch strobe |
| io_i | input | 8 | Bus byte |
| wp_ni | input | 1 | Write protect, active low (high means unprotected) |
| exec_o | output | 1 | One-cycle execute pulse |
| exec_op_o | output | 4 | Operation code, valid while `exec_o` is high |
| addr_o | output | 40 | Accumulated address |
| addr_cnt_o | output | 3 | Address bytes taken since the last clear |
| col_off_o | output | 12 | Column start offset |
| cmd_o | output | 8 | Current command |
| err_o | output | 1 | Unknown opcode flag, one cycle |

## Verification
Every result of this block comes out of one register stage. An execute pulse, an error flag, and any change of command, address, count or column show up in the cycle right after the clock edge that sampled the byte. The driver presents each byte for one cycle and queues the expected pulse or error before that byte. At the next falling edge, the monitor pops the queue and compares the result. Just after that edge, the driver checks that the queue has drained, so an event that comes a cycle late, or never comes, is reported even if its contents would match. Address, count, column and command are compared in that same window, and a gated commit or a dropped byte is shown to have no effect through these outputs.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int ADDR_BYTES = 5;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int CNT_W      = 3;
  localparam int COL_W      = 12;

  typedef enum logic [3:0] {
    OP_NONE         = 4'd0,
    OP_READ         = 4'd1,
    OP_READ_ID      = 4'd2,
    OP_RAND_READ    = 4'd3,
    OP_PROG_SETUP   = 4'd4,
    OP_PROG_COMMIT  = 4'd5,
    OP_ERASE_SETUP  = 4'd6,
    OP_ERASE_COMMIT = 4'd7,
    OP_STATUS       = 4'd8,
    OP_RESET        = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    K_SKIP, K_READ, K_COLRST, K_LATCH, K_IMM, K_UNK
  } kind_e;

  localparam logic [7:0] OPC_RD_MAIN  = 8'h00;
  localparam logic [7:0] OPC_RD_HALF  = 8'h01;
  localparam logic [7:0] OPC_RD_SPARE = 8'h50;
  localparam logic [7:0] OPC_RD_CONF  = 8'h30;
  localparam logic [7:0] OPC_COL_SEL  = 8'h05;
  localparam logic [7:0] OPC_COL_GO   = 8'hE0;
  localparam logic [7:0] OPC_COL_GO2  = 8'h35;
  localparam logic [7:0] OPC_IDENT    = 8'h90;
  localparam logic [7:0] OPC_PRG_LOAD = 8'h80;
  localparam logic [7:0] OPC_PRG_GO   = 8'h10;
  localparam logic [7:0] OPC_ERS_LOAD = 8'h60;
  localparam logic [7:0] OPC_ERS_GO   = 8'hD0;
  localparam logic [7:0] OPC_STAT     = 8'h70;
  localparam logic [7:0] OPC_RESET    = 8'hFF;
endpackage

// File: rtl/nand_opc_decode.sv
module nand_opc_decode
  import nand_seq_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1,
  parameter int PAGE_BYTES = 2048
) (
  input  logic [7:0]       opc_i,
  input  logic [7:0]       cur_cmd_i,
  output kind_e            kind_o,
  output op_e              op_o,
  output logic [COL_W-1:0] col_o
);
  always_comb begin
    kind_o = K_UNK;
    op_o   = OP_NONE;
    col_o  = '0;
    case (opc_i)
      OPC_RD_MAIN:  kind_o = K_READ;
      OPC_RD_HALF:  begin kind_o = K_READ; col_o = COL_W'(256); end
      OPC_RD_SPARE: begin kind_o = K_READ; col_o = COL_W'(PAGE_BYTES); end
      OPC_RD_CONF:  if (LARGE_PAGE && cur_cmd_i == OPC_RD_MAIN) kind_o = K_SKIP;
      OPC_COL_SEL:  if (LARGE_PAGE) kind_o = K_COLRST;
      OPC_PRG_LOAD, OPC_IDENT: kind_o = K_LATCH;
      OPC_STAT:     begin kind_o = K_IMM; op_o = OP_STATUS; end
      OPC_PRG_GO:   begin kind_o = K_IMM; op_o = OP_PROG_COMMIT; end
      OPC_ERS_LOAD: begin kind_o = K_IMM; op_o = OP_ERASE_SETUP; end
      OPC_ERS_GO:   begin kind_o = K_IMM; op_o = OP_ERASE_COMMIT; end
      OPC_RESET:    begin kind_o = K_IMM; op_o = OP_RESET; end
      OPC_COL_GO, OPC_COL_GO2:
        if (LARGE_PAGE) begin kind_o = K_IMM; op_o = OP_RAND_READ; end
      default: ;
    endcase
  end
endmodule

// File: rtl/nand_addr_accum.sv
module nand_addr_accum
  import nand_seq_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1,
  parameter bit BUS16      = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              take_i,
  input  logic              clr_cnt_i,
  input  logic              col_clr_i,
  input  logic              erase_shift_i,
  input  logic              soft_rst_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  cnt_nxt_o,
  output logic              taken_o
);
  localparam int ROW_SHIFT = LARGE_PAGE ? 16 : 8;
  localparam int COL_BITS  = LARGE_PAGE ? 16 : 8;
  localparam logic [ADDR_W-1:0] COL_MASK = (ADDR_W'(1) << COL_BITS) - ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q, ins;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    ins = addr_q;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt_q == CNT_W'(i)) ins[8*i +: 8] = byte_i;
  end

  assign taken_o   = take_i && (cnt_q < CNT_W'(ADDR_BYTES));
  assign cnt_nxt_o = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (soft_rst_i) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (erase_shift_i) begin
      addr_q <= addr_q << ROW_SHIFT;
      cnt_q  <= '0;
    end else if (col_clr_i) begin
      addr_q <= addr_q & ~COL_MASK;
      cnt_q  <= '0;
    end else if (clr_cnt_i) begin
      cnt_q  <= '0;
    end else if (taken_o) begin
      cnt_q  <= cnt_nxt_o;
      // 16-bit bus: word column becomes a byte column
      addr_q <= (BUS16 && cnt_nxt_o == CNT_W'(2)) ? (ins << 1) : ins;
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1,
  parameter bit BIG_CAP    = 1'b1,
  parameter bit BUS16      = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              ce_ni,
  input  logic              cle_i,
  input  logic              ale_i,
  input  logic [7:0]        io_i,
  input  logic              wp_ni,
  output logic              exec_o,
  output logic [3:0]        exec_op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  addr_cnt_o,
  output logic [COL_W-1:0]  col_off_o,
  output logic [7:0]        cmd_o,
  output logic              err_o
);
  localparam int PAGE_BYTES = LARGE_PAGE ? 2048 : 512;
  localparam int LAUNCH_CYC = LARGE_PAGE ? (BIG_CAP ? 5 : 4) : 3;

  logic             cmd_stb, addr_stb;
  kind_e            dec_kind;
  op_e              dec_op;
  logic [COL_W-1:0] dec_col;
  logic [7:0]       cmd_q;
  logic [COL_W-1:0] col_q;
  logic             exec_q, err_q;
  op_e              op_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             taken, launch, gated, clr_cnt;
  op_e              launch_op;

  assign cmd_stb  = we_i && !ce_ni && cle_i;
  assign addr_stb = we_i && !ce_ni && ale_i && !cle_i;

  nand_opc_decode #(.LARGE_PAGE(LARGE_PAGE), .PAGE_BYTES(PAGE_BYTES)) u_dec (
    .opc_i(io_i), .cur_cmd_i(cmd_q), .kind_o(dec_kind), .op_o(dec_op), .col_o(dec_col)
  );

  assign clr_cnt = cmd_stb && (dec_kind == K_READ || dec_kind == K_LATCH || dec_kind == K_IMM)
                   && io_i != OPC_COL_GO;

  nand_addr_accum #(.LARGE_PAGE(LARGE_PAGE), .BUS16(BUS16)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(io_i), .take_i(addr_stb),
    .clr_cnt_i(clr_cnt),
    .col_clr_i(cmd_stb && dec_kind == K_COLRST),
    .erase_shift_i(cmd_stb && dec_op == OP_ERASE_COMMIT),
    .soft_rst_i(cmd_stb && dec_op == OP_RESET),
    .addr_o(addr_o), .cnt_o(addr_cnt_o), .cnt_nxt_o(cnt_nxt), .taken_o(taken)
  );

  always_comb begin
    launch    = 1'b0;
    launch_op = OP_NONE;
    if (taken) begin
      if (cmd_q == OPC_IDENT && cnt_nxt == CNT_W'(1)) begin
        launch = 1'b1; launch_op = OP_READ_ID;
      end else if (cnt_nxt == CNT_W'(LAUNCH_CYC)) begin
        if (cmd_q == OPC_RD_MAIN) begin launch = 1'b1; launch_op = OP_READ; end
        else if (cmd_q == OPC_PRG_LOAD) begin launch = 1'b1; launch_op = OP_PROG_SETUP; end
      end
    end
  end

  assign gated = (dec_op == OP_PROG_COMMIT || dec_op == OP_ERASE_COMMIT) && !wp_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= OPC_RD_MAIN;
      col_q  <= '0;
      exec_q <= 1'b0;
      err_q  <= 1'b0;
      op_q   <= OP_NONE;
    end else begin
      exec_q <= 1'b0;
      err_q  <= 1'b0;
      op_q   <= OP_NONE;
      if (cmd_stb) begin
        case (dec_kind)
          K_READ: begin
            cmd_q <= OPC_RD_MAIN;
            col_q <= dec_col;
          end
          K_LATCH: cmd_q <= io_i;
          K_IMM: begin
            if (dec_op == OP_RESET) begin
              cmd_q <= OPC_RD_MAIN;
              col_q <= '0;
            end else begin
              cmd_q <= io_i;
            end
            if (!gated) begin
              exec_q <= 1'b1;
              op_q   <= dec_op;
            end
          end
          K_UNK: err_q <= 1'b1;
          default: ;
        endcase
      end else if (launch) begin
        exec_q <= 1'b1;
        op_q   <= launch_op;
      end
    end
  end

  assign exec_o    = exec_q;
  assign exec_op_o = op_q;
  assign col_off_o = col_q;
  assign cmd_o     = cmd_q;
  assign err_o     = err_q;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk
  import nand_seq_pkg::*;
#(
  parameter bit LARGE_PAGE = 1'b1,
  parameter bit BIG_CAP    = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              ce_ni,
  input logic              cle_i,
  input logic              wp_ni,
  input logic              exec_o,
  input logic [3:0]        exec_op_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [CNT_W-1:0]  addr_cnt_o,
  input logic [COL_W-1:0]  col_off_o,
  input logic [7:0]        cmd_o,
  input logic              err_o
);
  localparam int LAUNCH_CYC = LARGE_PAGE ? (BIG_CAP ? 5 : 4) : 3;

  assert_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_o && err_o));

  assert_exec_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> $past(we_i && !ce_ni));

  assert_cmd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(we_i && !ce_ni && cle_i)) |-> $stable(cmd_o));

  assert_wp_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && (exec_op_o == OP_PROG_COMMIT || exec_op_o == OP_ERASE_COMMIT)) |-> $past(wp_ni));

  assert_cnt_max_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_cnt_o <= CNT_W'(ADDR_BYTES));

  assert_launch_cnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && (exec_op_o == OP_READ || exec_op_o == OP_PROG_SETUP)) |-> addr_cnt_o == CNT_W'(LAUNCH_CYC));

  assert_ident_cnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && exec_op_o == OP_READ_ID) |-> addr_cnt_o == CNT_W'(1));

  assert_err_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(we_i && !ce_ni && cle_i) && $stable(cmd_o) && $stable(addr_o)));

  assert_soft_rst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && exec_op_o == OP_RESET) |-> (cmd_o == 8'h00 && addr_o == '0 && addr_cnt_o == '0 && col_off_o == '0));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.LARGE_PAGE(LARGE_PAGE), .BIG_CAP(BIG_CAP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .ce_ni(ce_ni), .cle_i(cle_i), .wp_ni(wp_ni),
  .exec_o(exec_o), .exec_op_o(exec_op_o), .addr_o(addr_o), .addr_cnt_o(addr_cnt_o),
  .col_off_o(col_off_o), .cmd_o(cmd_o), .err_o(err_o)
);

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
  typedef struct packed {
    logic        is_err;
    logic [3:0]  op;
    logic [39:0] addr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
  logic [2:0] ce_n = 3'b111;
  logic [7:0] io = 8'h00;

  logic        exec_w [3];
  logic [3:0]  op_w   [3];
  logic [39:0] addr_w [3];
  logic [2:0]  cnt_w  [3];
  logic [11:0] col_w  [3];
  logic [7:0]  cmd_w  [3];
  logic        err_w  [3];

  exp_t sb [3][$];
  exp_t e;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // dut0: large page, >=2 Gbit, 8-bit bus
  nand_cmd_seq #(.LARGE_PAGE(1'b1), .BIG_CAP(1'b1), .BUS16(1'b0)) u_nand_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .ce_ni(ce_n[0]), .cle_i(cle), .ale_i(ale),
    .io_i(io), .wp_ni(wp_n), .exec_o(exec_w[0]), .exec_op_o(op_w[0]), .addr_o(addr_w[0]),
    .addr_cnt_o(cnt_w[0]), .col_off_o(col_w[0]), .cmd_o(cmd_w[0]), .err_o(err_w[0]));
  // dut1: small page, 16-bit bus
  nand_cmd_seq #(.LARGE_PAGE(1'b0), .BIG_CAP(1'b0), .BUS16(1'b1)) u_nand_cmd_seq_sp (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .ce_ni(ce_n[1]), .cle_i(cle), .ale_i(ale),
    .io_i(io), .wp_ni(wp_n), .exec_o(exec_w[1]), .exec_op_o(op_w[1]), .addr_o(addr_w[1]),
    .addr_cnt_o(cnt_w[1]), .col_off_o(col_w[1]), .cmd_o(cmd_w[1]), .err_o(err_w[1]));
  // dut2: large page, below 2 Gbit
  nand_cmd_seq #(.LARGE_PAGE(1'b1), .BIG_CAP(1'b0), .BUS16(1'b0)) u_nand_cmd_seq_lps (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .ce_ni(ce_n[2]), .cle_i(cle), .ale_i(ale),
    .io_i(io), .wp_ni(wp_n), .exec_o(exec_w[2]), .exec_op_o(op_w[2]), .addr_o(addr_w[2]),
    .addr_cnt_o(cnt_w[2]), .col_off_o(col_w[2]), .cmd_o(cmd_w[2]), .err_o(err_w[2]));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_ex(input int d, input logic [3:0] op, input logic [39:0] a);
    sb[d].push_back('{is_err: 1'b0, op: op, addr: a});
  endtask

  task automatic push_err(input int d);
    sb[d].push_back('{is_err: 1'b1, op: 4'd0, addr: 40'd0});
  endtask

  // one byte for one cycle; d = 3 keeps every chip deselected
  task automatic wr(input int d, input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    ce_n = 3'b111;
    if (d < 3) ce_n[d] = 1'b0;
    cle = c; ale = a; io = b; we = 1'b1;
    @(negedge clk);
    we = 1'b0; cle = 1'b0; ale = 1'b0; ce_n = 3'b111;
    #1;
    for (int k = 0; k < 3; k++) chk("R13 event due one cycle after byte", 64'(sb[k].size()), 64'd0);
  endtask

  task automatic cmd(input int d, input logic [7:0] b); wr(d, 1'b1, 1'b0, b); endtask
  task automatic adr(input int d, input logic [7:0] b); wr(d, 1'b0, 1'b1, b); endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 3; d++) begin
        if (exec_w[d] || err_w[d]) begin
          nchk++;
          if (sb[d].size() == 0) begin
            nerr++;
            $display("FAIL R13 dut%0d unexpected actual=exec%0b/err%0b op%0d expected=none",
                     d, exec_w[d], err_w[d], op_w[d]);
          end else begin
            e = sb[d].pop_front();
            if (e.is_err) begin
              if (!(err_w[d] && !exec_w[d])) begin
                nerr++;
                $display("FAIL R12 dut%0d actual=exec%0b/err%0b expected=err", d, exec_w[d], err_w[d]);
              end
            end else if (!(exec_w[d] && !err_w[d] && op_w[d] == e.op && addr_w[d] == e.addr)) begin
              nerr++;
              $display("FAIL R5/R13 dut%0d actual=op%0d addr%0h expected=op%0d addr%0h",
                       d, op_w[d], addr_w[d], e.op, e.addr);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd", 64'(cmd_w[0]), 64'h00);
    chk("R1 addr", 64'(addr_w[0]), 64'h0);
    chk("R1 cnt", 64'(cnt_w[0]), 64'd0);
    chk("R1 col", 64'(col_w[0]), 64'd0);
    chk("R1 exec/err", 64'({exec_w[0], err_w[0]}), 64'd0);

    // R4 read after 5th byte, R2 lane order
    cmd(0, 8'h00);
    adr(0, 8'h11); adr(0, 8'h22); adr(0, 8'h33); adr(0, 8'h44);
    chk("R4 cnt before launch", 64'(cnt_w[0]), 64'd4);
    push_ex(0, 4'd1, 40'h5544332211);
    adr(0, 8'h55);
    chk("R2 addr lanes", 64'(addr_w[0]), 64'h5544332211);
    adr(0, 8'h66);
    chk("R4 count saturates, byte dropped", 64'(addr_w[0]), 64'h5544332211);

    // R7 confirm ignored, column select
    cmd(0, 8'h30);
    chk("R7 0x30 ignored cmd", 64'(cmd_w[0]), 64'h00);
    chk("R7 0x30 ignored cnt", 64'(cnt_w[0]), 64'd5);
    cmd(0, 8'h05);
    chk("R7 col bits cleared", 64'(addr_w[0]), 64'h5544330000);
    chk("R7 cnt cleared", 64'(cnt_w[0]), 64'd0);
    chk("R7 cmd kept", 64'(cmd_w[0]), 64'h00);
    adr(0, 8'h34); adr(0, 8'h12);
    push_ex(0, 4'd3, 40'h5544331234);
    cmd(0, 8'hE0);
    chk("R6 0xE0 keeps cnt", 64'(cnt_w[0]), 64'd2);

    // R3 column offsets
    cmd(0, 8'h50);
    chk("R3 spare col", 64'(col_w[0]), 64'h800);
    chk("R3 cmd 0x00", 64'(cmd_w[0]), 64'h00);
    chk("R6 cnt cleared", 64'(cnt_w[0]), 64'd0);
    cmd(0, 8'h01);
    chk("R3 half col", 64'(col_w[0]), 64'h100);
    cmd(0, 8'h00);
    chk("R3 zero col", 64'(col_w[0]), 64'h0);

    // R4 read-ID after first byte
    cmd(0, 8'h90);
    push_ex(0, 4'd2, 40'h5544331200);
    adr(0, 8'h00);

    // R8 erase shift, R5 erase ops
    push_ex(0, 4'd6, 40'h5544331200);
    cmd(0, 8'h60);
    adr(0, 8'h01); adr(0, 8'h02); adr(0, 8'h03);
    push_ex(0, 4'd7, 40'h0302010000);
    cmd(0, 8'hD0);
    chk("R8 row shift 16", 64'(addr_w[0]), 64'h0302010000);

    // R9 protected erase: shift still, no pulse
    wp_n = 1'b0;
    push_ex(0, 4'd6, 40'h0302010000);
    cmd(0, 8'h60);
    cmd(0, 8'hD0);
    chk("R9 R8 protected erase shift", 64'(addr_w[0]), 64'h0100000000);

    // R9 program gating
    cmd(0, 8'h80);
    adr(0, 8'hA1); adr(0, 8'hA2); adr(0, 8'hA3); adr(0, 8'hA4);
    push_ex(0, 4'd4, 40'hA5A4A3A2A1);
    adr(0, 8'hA5);
    cmd(0, 8'h10);
    wp_n = 1'b1;
    push_ex(0, 4'd5, 40'hA5A4A3A2A1);
    cmd(0, 8'h10);

    // R5 status
    push_ex(0, 4'd8, 40'hA5A4A3A2A1);
    cmd(0, 8'h70);
    chk("R5 status cmd", 64'(cmd_w[0]), 64'h70);

    // R12 unknown opcode
    push_err(0);
    cmd(0, 8'h85);
    chk("R12 cmd unchanged", 64'(cmd_w[0]), 64'h70);
    chk("R12 addr unchanged", 64'(addr_w[0]), 64'hA5A4A3A2A1);

    // R2 deselected bytes ignored
    cmd(3, 8'h00);
    adr(3, 8'h77);
    chk("R2 ce high cmd", 64'(cmd_w[0]), 64'h70);
    chk("R2 ce high addr", 64'(addr_w[0]), 64'hA5A4A3A2A1);

    // R11 reset command
    cmd(0, 8'h50);
    push_ex(0, 4'd9, 40'h0);
    cmd(0, 8'hFF);
    chk("R11 cmd", 64'(cmd_w[0]), 64'h00);
    chk("R11 col", 64'(col_w[0]), 64'h0);
    chk("R11 addr", 64'(addr_w[0]), 64'h0);
    chk("R11 cnt", 64'(cnt_w[0]), 64'd0);

    // dut1: small page, 16-bit bus
    cmd(1, 8'h00);
    adr(1, 8'h12); adr(1, 8'h34);
    chk("R10 word to byte column", 64'(addr_w[1]), 64'h6824);
    push_ex(1, 4'd1, 40'h566824);
    adr(1, 8'h56);
    push_err(1);
    cmd(1, 8'h30);  // R7 unknown in small page
    cmd(1, 8'h50);
    chk("R3 small spare col", 64'(col_w[1]), 64'h200);
    push_ex(1, 4'd6, 40'h566824);
    cmd(1, 8'h60);
    adr(1, 8'h01); adr(1, 8'h02);
    chk("R10 shift on 2nd byte", 64'(addr_w[1]), 64'hAC0402);
    push_ex(1, 4'd7, 40'hAC040200);
    cmd(1, 8'hD0);
    chk("R8 row shift 8", 64'(addr_w[1]), 64'hAC040200);

    // dut2: large page below 2 Gbit, launch on 4th byte
    cmd(2, 8'h80);
    adr(2, 8'h01); adr(2, 8'h02); adr(2, 8'h03);
    push_ex(2, 4'd4, 40'h04030201);
    adr(2, 8'h04);
    chk("R4 4-byte launch cnt", 64'(cnt_w[2]), 64'd4);
    adr(2, 8'h05);
    chk("R4 no relaunch cnt", 64'(cnt_w[2]), 64'd5);

    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) chk("R13 scoreboard drained", 64'(sb[k].size()), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule